// File: doc/BRIEF.md
# Position-Based Motor Commutation Sequencer

This block drives the six gate signals of a three-phase brushless DC motor from a signed shaft position count, such as a quadrature decoder produces, so the motor needs no hall sensors. A signed offset is added to the position. The sum is then folded into one electrical revolution using a programmable counts-per-revolution value. The folded angle is compared against a table of up to eight upper boundaries, and the matching entry supplies the six-bit drive pattern.

The host loads the revolution length, the boundary and pattern table, the offset and the enable through a simple register write port. The offset can be rewritten while the motor turns. This moves every switching point earlier or later together, which helps hold torque at high speed. Each phase has a guard that prevents both of its switches from being on at the same time. The outputs come from a register and are forced low while the block is disabled.

Top module: `pos_commutator`

## Requirements
- R1: After reset, all six drive outputs are low, the enable is clear, and the offset, revolution length, boundaries and patterns are all zero.
- R2: While the enable (control register, address 0, bit 0) is clear, all drive outputs are low in every cycle, whatever the position and table hold.
- R3: The drive outputs come from a register. The pattern for a position presented before a rising edge appears on the outputs just after that edge.
- R4: The lookup angle is (position + offset) reduced modulo the revolution length into the range 0 to length-1, and negative sums wrap upward.
- R5: The selected entry is the lowest-numbered entry whose boundary is strictly greater than the angle. When no boundary is greater, the last entry (index 7) is selected.
- R6: The drive bus carries the high-side switch of phase k on bit 2k and the low-side switch of phase k on bit 2k+1, for k = 0, 1, 2, copied from the selected pattern.
- R7: If the selected pattern has both switches of a phase set, both outputs of that phase are low, and the other phases are unaffected.
- R8: A new offset written while enabled changes the output from the edge after the write, and commutation is not paused.
- R9: The write addresses are: 1 = offset (data bits 15:0, signed), 2 = revolution length (bits 15:0, unsigned), 8+i = table entry i (bits 15:0 boundary, bits 21:16 pattern). Writes to any other address are ignored.
- R10: A revolution length of zero makes the lookup angle zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pos_i | input | 24 | Signed shaft position count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| drv_o | output | 6 | Gate drives, high side on even bits and low side on odd bits |

## Verification
A wrong fold of the angle, a mis-ordered boundary compare or a stale offset shows up as a wrong pattern on the drive bus on the edge right after the offending position or write. This is because every stage between the position input and the output is combinational except the final register. The bench sweeps the position across several revolutions, through negative values and across every boundary, and changes the offset in the middle of a sweep. It compares the outputs against its model on every clock, so a divergence is caught within one cycle.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
   localparam int PHASES   = 3;
   localparam int PAT_W    = 2 * PHASES;
   localparam int ADDR_W   = 4;
   localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
   localparam logic [ADDR_W-1:0] A_OFS  = 4'd1;
   localparam logic [ADDR_W-1:0] A_REV  = 4'd2;
   localparam int TAB_BASE = 8;
   localparam int FLD_LSB  = 16;
   typedef logic [PAT_W-1:0] drv_pat_t;
endpackage

// File: rtl/cmt_regfile.sv
module cmt_regfile
   import cmt_pkg::*;
#(
   parameter int N_ENT  = 8,
   parameter int ANG_W  = 16,
   parameter int OFS_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en_i,
   input  logic [ADDR_W-1:0]            wr_addr_i,
   input  logic [DATA_W-1:0]            wr_data_i,
   output logic                         en_o,
   output logic signed [OFS_W-1:0]      ofs_o,
   output logic [ANG_W-1:0]             rev_o,
   output logic [N_ENT-1:0][ANG_W-1:0]  bnd_o,
   output drv_pat_t [N_ENT-1:0]         pat_o
);
   localparam int PAT_TOP = FLD_LSB + PAT_W;

   if (DATA_W < PAT_TOP || ANG_W > FLD_LSB || OFS_W > FLD_LSB) begin : g_bad_w
      $error("cmt_regfile: field widths do not fit the write data");
   end

   logic unused_hi;
   assign unused_hi = ^wr_data_i[DATA_W-1:PAT_TOP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o  <= 1'b0;
         ofs_o <= '0;
         rev_o <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == A_CTRL) en_o  <= wr_data_i[0];
         if (wr_addr_i == A_OFS)  ofs_o <= wr_data_i[OFS_W-1:0];
         if (wr_addr_i == A_REV)  rev_o <= wr_data_i[ANG_W-1:0];
      end
   end

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(TAB_BASE + e);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bnd_o[e] <= '0;
            pat_o[e] <= '0;
         end else if (wr_en_i && wr_addr_i == MY_ADDR) begin
            bnd_o[e] <= wr_data_i[ANG_W-1:0];
            pat_o[e] <= wr_data_i[PAT_TOP-1:FLD_LSB];
         end
      end
   end

   AST_OFS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == A_OFS) |=> (ofs_o == $past(wr_data_i[OFS_W-1:0]))); // R9
   AST_REV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == A_REV) |=> (rev_o == $past(wr_data_i[ANG_W-1:0]))); // R9
endmodule

// File: rtl/cmt_angle_wrap.sv
module cmt_angle_wrap #(
   parameter int POS_W = 24,
   parameter int OFS_W = 16,
   parameter int ANG_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [POS_W-1:0] pos_i,
   input  logic signed [OFS_W-1:0] ofs_i,
   input  logic [ANG_W-1:0]        rev_i,
   output logic [ANG_W-1:0]        ang_o
);
   localparam int SUM_W = POS_W + 1;

   if (POS_W < OFS_W || POS_W < ANG_W) begin : g_bad_w
      $error("cmt_angle_wrap: position must be at least as wide as offset and angle");
   end

   logic signed [SUM_W-1:0] sum, dvs, rem, fold;

   always_comb begin
      sum = SUM_W'(pos_i) + SUM_W'(ofs_i);
      dvs = $signed({{(SUM_W-ANG_W){1'b0}}, rev_i});
      rem = '0;
      if (rev_i != '0) rem = sum % dvs;
      fold = (rem < 0) ? rem + dvs : rem;
      ang_o = fold[ANG_W-1:0];
   end

   AST_ANGLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rev_i != '0) |-> (ang_o < rev_i)); // R4
   AST_ZERO_REV: assert property (@(posedge clk) disable iff (!rst_n)
      (rev_i == '0) |-> (ang_o == '0)); // R10
endmodule

// File: rtl/cmt_state_lookup.sv
module cmt_state_lookup
   import cmt_pkg::*;
#(
   parameter int N_ENT = 8,
   parameter int ANG_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ANG_W-1:0]            ang_i,
   input  logic [N_ENT-1:0][ANG_W-1:0] bnd_i,
   input  drv_pat_t [N_ENT-1:0]        pat_i,
   output drv_pat_t                    pat_o
);
   localparam int IDX_W = $clog2(N_ENT);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

   if (N_ENT < 2 || N_ENT > 8) begin : g_bad_n
      $error("cmt_state_lookup: entry count must be 2..8");
   end

   logic [N_ENT-1:0] below;
   logic [IDX_W-1:0] idx;

   for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
      assign below[e] = ang_i < bnd_i[e];
   end

   always_comb begin
      idx = LAST;
      for (int e = N_ENT - 1; e >= 0; e--) begin
         if (below[e]) idx = IDX_W'(e);
      end
      pat_o = pat_i[idx];
   end

   AST_HIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (idx != LAST) |-> (ang_i < bnd_i[idx])); // R5
   AST_NONE_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == '0) || (ang_i >= bnd_i[idx - IDX_W'(1)])); // R5
endmodule

// File: rtl/cmt_phase_guard.sv
module cmt_phase_guard
   import cmt_pkg::*;
(
   input  drv_pat_t pat_i,
   output drv_pat_t pat_o
);
   for (genvar p = 0; p < PHASES; p++) begin : g_ph
      logic clash;
      assign clash = pat_i[2*p] & pat_i[2*p+1];
      assign pat_o[2*p]   = pat_i[2*p]   & ~clash;
      assign pat_o[2*p+1] = pat_i[2*p+1] & ~clash;
   end
endmodule

// File: rtl/pos_commutator.sv
module pos_commutator
   import cmt_pkg::*;
#(
   parameter int POS_W  = 24,
   parameter int OFS_W  = 16,
   parameter int ANG_W  = 16,
   parameter int N_ENT  = 8,
   parameter int DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [POS_W-1:0] pos_i,
   input  logic                    wr_en_i,
   input  logic [ADDR_W-1:0]       wr_addr_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   output logic [PAT_W-1:0]        drv_o
);
   logic                        en;
   logic signed [OFS_W-1:0]     ofs;
   logic [ANG_W-1:0]            rev, ang;
   logic [N_ENT-1:0][ANG_W-1:0] bnd;
   drv_pat_t [N_ENT-1:0]        pat;
   drv_pat_t                    raw, safe;

   cmt_regfile #(.N_ENT(N_ENT), .ANG_W(ANG_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .en_o(en), .ofs_o(ofs), .rev_o(rev),
      .bnd_o(bnd), .pat_o(pat));

   cmt_angle_wrap #(.POS_W(POS_W), .OFS_W(OFS_W), .ANG_W(ANG_W)) wrap_i (
      .clk(clk), .rst_n(rst_n), .pos_i(pos_i), .ofs_i(ofs), .rev_i(rev), .ang_o(ang));

   cmt_state_lookup #(.N_ENT(N_ENT), .ANG_W(ANG_W)) look_i (
      .clk(clk), .rst_n(rst_n), .ang_i(ang), .bnd_i(bnd), .pat_i(pat), .pat_o(raw));

   cmt_phase_guard guard_i (.pat_i(raw), .pat_o(safe));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   drv_o <= '0;
      else if (en)  drv_o <= safe;
      else          drv_o <= '0;
   end

   AST_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (drv_o == '0)); // R2
   AST_FOLLOWS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (drv_o == $past(safe))); // R3

   for (genvar p = 0; p < PHASES; p++) begin : g_chk
      AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
         !(drv_o[2*p] && drv_o[2*p+1])); // R7
   end
endmodule

// File: tb/pos_commutator_tb.sv
module pos_commutator_tb_top;
   localparam int CLK_NS = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [23:0] pos = '0;
   logic               wr_en = 1'b0;
   logic [3:0]         wr_addr = '0;
   logic [31:0]        wr_data = '0;
   logic [5:0]         drv;

   int checks = 0, errors = 0, cycles = 0;
   string cur_req = "R1";

   int m_bnd[8], m_pat[8];
   int m_ofs, m_rev, m_en;
   logic [5:0] exp_drv = '0;

   pos_commutator dut_i (.clk(clk), .rst_n(rst_n), .pos_i(pos), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .drv_o(drv));

   always #(CLK_NS/2) clk = ~clk;

   function automatic logic [5:0] model_out(int p);
      int s, a, idx, pt;
      s = p + m_ofs;
      if (m_rev == 0) a = 0;
      else begin
         a = s % m_rev;
         if (a < 0) a += m_rev;
      end
      idx = 7;
      for (int i = 7; i >= 0; i--) if (a < m_bnd[i]) idx = i;
      pt = m_pat[idx];
      for (int ph = 0; ph < 3; ph++)
         if (((pt >> (2*ph)) & 3) == 3) pt = pt & ~(3 << (2*ph));
      return (m_en != 0) ? 6'(pt) : 6'd0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_drv = '0;
         m_ofs = 0; m_rev = 0; m_en = 0;
         for (int i = 0; i < 8; i++) begin m_bnd[i] = 0; m_pat[i] = 0; end
      end else begin
         exp_drv = model_out(int'(pos));
         if (wr_en) begin
            case (wr_addr)
               4'd0: m_en = int'(wr_data[0]);
               4'd1: m_ofs = int'($signed(wr_data[15:0]));
               4'd2: m_rev = int'(wr_data[15:0]);
               default:
                  if (wr_addr >= 4'd8) begin
                     m_bnd[wr_addr-8] = int'(wr_data[15:0]);
                     m_pat[wr_addr-8] = int'(wr_data[21:16]);
                  end
            endcase
         end
      end
   end

   always @(negedge clk) begin
      cycles++;
      checks++;
      if (drv !== exp_drv) begin
         errors++;
         $display("FAIL %s: drv=%b expected %b (pos=%0d)", cur_req, drv, exp_drv, pos);
      end
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 100000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ent(input int i, input int b, input logic [5:0] p);
      wr(4'(8 + i), {10'h3FF, p, 16'(b)});
   endtask

   task automatic step(input int p);
      @(negedge clk);
      pos = 24'(p);
   endtask

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      wr(4'd2, 32'd600);
      ent(0, 100, 6'b100001); ent(1, 200, 6'b100100); ent(2, 300, 6'b000110);
      ent(3, 400, 6'b010010); ent(4, 500, 6'b011000); ent(5, 600, 6'b001001);
      ent(6, 0, 6'b101010);   ent(7, 0, 6'b010101);

      cur_req = "R2";
      for (int p = 0; p < 700; p += 37) step(p);

      cur_req = "R9";
      wr(4'd0, 32'd1);
      wr(4'd3, 32'd77);
      wr(4'd5, 32'hFFFF);
      step(150); step(150);

      cur_req = "R5";
      for (int b = 0; b < 6; b++) begin
         step(b*100 - 1); step(b*100); step(b*100 + 99);
      end

      cur_req = "R3";
      for (int p = 0; p < 1800; p += 7) step(p);

      cur_req = "R6";
      for (int p = 50; p < 600; p += 100) step(p);

      cur_req = "R4";
      step(-1); step(-600); step(-601); step(-8388608); step(8388607); step(-250);

      cur_req = "R8";
      for (int p = 0; p < 300; p += 11) begin
         step(p);
         if (p == 99)  wr(4'd1, 32'd50);
         if (p == 198) wr(4'd1, 32'h0000FF6A);
      end
      wr(4'd1, 32'd0);

      cur_req = "R7";
      ent(0, 100, 6'b000011);
      step(20); step(30);
      ent(0, 100, 6'b111111);
      step(40); step(45);
      ent(0, 100, 6'b110011);
      step(10); step(11);

      cur_req = "R5";
      wr(4'd2, 32'd1000);
      step(650); step(999); step(700);

      cur_req = "R10";
      wr(4'd2, 32'd0);
      step(555); step(-3);

      cur_req = "R2";
      wr(4'd2, 32'd600);
      wr(4'd0, 32'd0);
      for (int p = 0; p < 600; p += 53) step(p);

      cur_req = "R1";
      @(negedge clk); rst_n = 1'b0;
      step(250); step(250);
      rst_n = 1'b1;
      wr(4'd0, 32'd1);
      step(250); step(250);

      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule